// File: doc/BRIEF.md
# Blocking Write-Back Data Cache Controller

This block is a direct-mapped data cache between a processor and a slower main memory. It stores 1024 lines of four 32-bit words, 16 KB in all, and uses 32-bit byte addresses. Writes stay in the cache and mark the line as modified. Main memory is only updated when a modified line is evicted. A write miss first brings the line in from memory and then merges the processor's word into it.

The processor raises a request with an address, a direction and write data. It holds that request until the cache answers with a one-cycle ready pulse, and only one access is in flight at a time. On the memory side every transfer moves one whole 128-bit line. Each transfer uses the same request/ready handshake and may take any number of cycles.

A four-state controller sequences each access: wait, tag compare, eviction of a modified victim, and line fetch. After a fetch the controller goes back to tag compare, so every access ends as a hit.

Top module: `wbc_top`

## Requirements
- R1: A byte address is decoded as tag = bits 31:14, line index = bits 13:4 and word select = bits 3:2. Bits 1:0 are ignored. Two addresses hit the same line only if both their tag and their index are equal.
- R2: After reset every line is invalid and clean. The first access to any line fetches it from memory without any eviction write.
- R3: A read hit returns the selected word on `cpu_rdata` together with the `cpu_ready` pulse, and starts no memory transfer.
- R4: A write hit changes only the cached word and marks the line modified. No memory transfer takes place.
- R5: A miss on a valid, modified line first writes the victim's full 128-bit line to memory. The write address is {victim tag, index, 4'b0000}. Only after that write is acknowledged is the new line requested.
- R6: A miss on an invalid or clean line issues exactly one memory read at {new tag, index, 4'b0000} and no write.
- R7: A write miss fetches the line and then merges the written word into it. Later reads return the written word, and the other three words keep their values from memory. Word k of a 128-bit line sits at bits 32k+31:32k.
- R8: `cpu_ready` is a single-cycle pulse that is given only for an outstanding request and never while a memory transfer is active. A hit completes two cycles after the request is presented.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_addr` and `mem_we` do not change. Every memory address is line-aligned (bits 3:0 are zero).
- R10: When a line fetch is acknowledged, `mem_req` drops in the next cycle and the access completes as a hit one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Evicted line data |
| mem_rdata | input | 128 | Fetched line data, valid with mem_ready |
| mem_ready | input | 1 | Memory completion pulse |

## Verification
The assertions assume three things about the environment:
- The processor keeps `cpu_req` high until it sees `cpu_ready`, then drops it.
- The memory answers each request with a one-cycle `mem_ready` pulse, and only while `mem_req` is high.
- `mem_rdata` is valid in the same cycle as that pulse.

The bench's memory model answers only an active request, after a random delay of one to four cycles, and it never repeats the pulse. The processor driver waits one idle cycle after each completion, so every hit shows its full latency. Random addresses use only a few tags over a few indices, plus the top index, so that conflict evictions happen often.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMP   = 2'd1,
    ST_EVICT = 2'd2,
    ST_FETCH = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] dirty_q;
  logic [TAG_W-1:0] tag_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[idx] <= fill_tag;
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_mem[idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int IDX_W  = 10,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic [IDX_W-1:0]        idx,
  output logic [WORDS*WORD_W-1:0] line,
  input  logic                    fill_en,
  input  logic [WORDS*WORD_W-1:0] fill_line,
  input  logic                    word_en,
  input  logic [$clog2(WORDS)-1:0] word_sel,
  input  logic [WORD_W-1:0]       word_data
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    logic [WORD_W-1:0] lane_mem [DEPTH];
    logic              lane_hit;
    assign lane_hit = word_en && (word_sel == g[$clog2(WORDS)-1:0]);
    always_ff @(posedge clk) begin
      if (fill_en)       lane_mem[idx] <= fill_line[g*WORD_W +: WORD_W];
      else if (lane_hit) lane_mem[idx] <= word_data;
    end
    assign line[g*WORD_W +: WORD_W] = lane_mem[idx];
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 4,
  parameter int TAG_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [WORD_W-1:0]        cpu_wdata,
  output logic [WORD_W-1:0]        cpu_rdata,
  output logic                     cpu_ready,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [WORDS*WORD_W-1:0]  mem_wdata,
  input  logic                     mem_ready,
  output logic [IDX_W-1:0]         idx,
  input  logic                     line_valid,
  input  logic                     line_dirty,
  input  logic [TAG_W-1:0]         line_tag,
  input  logic [WORDS*WORD_W-1:0]  line,
  output logic                     fill_en,
  output logic [TAG_W-1:0]         fill_tag,
  output logic                     word_en,
  output logic [$clog2(WORDS)-1:0] word_sel,
  output logic [WORD_W-1:0]        word_data
);
  localparam int SEL_W = $clog2(WORDS);
  localparam int BYTE_W = OFF_W - SEL_W;

  wbc_state_e        state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [WORD_W-1:0] req_wdata_q;
  logic [TAG_W-1:0]  req_tag;
  logic              hit;

  assign idx       = req_addr_q[OFF_W +: IDX_W];
  assign req_tag   = req_addr_q[ADDR_W-1 -: TAG_W];
  assign word_sel  = req_addr_q[BYTE_W +: SEL_W];
  assign hit       = line_valid && (line_tag == req_tag);
  assign word_en   = (state_q == ST_CMP) && hit && req_we_q;
  assign word_data = req_wdata_q;
  assign fill_en   = (state_q == ST_FETCH) && mem_ready;
  assign fill_tag  = req_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      req_we_q    <= 1'b0;
      req_wdata_q <= '0;
      cpu_rdata   <= '0;
      cpu_ready   <= 1'b0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req && !cpu_ready) begin
            req_addr_q  <= cpu_addr;
            req_we_q    <= cpu_we;
            req_wdata_q <= cpu_wdata;
            state_q     <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (hit) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= line[word_sel*WORD_W +: WORD_W];
            state_q   <= ST_IDLE;
          end else if (line_valid && line_dirty) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {line_tag, idx, {OFF_W{1'b0}}};
            mem_wdata <= line;
            state_q   <= ST_EVICT;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {req_tag, idx, {OFF_W{1'b0}}};
            state_q  <= ST_FETCH;
          end
        end
        ST_EVICT: begin
          if (mem_ready) begin
            mem_we   <= 1'b0;
            mem_addr <= {req_tag, idx, {OFF_W{1'b0}}};
            state_q  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            state_q <= ST_CMP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbc_top.sv
module wbc_top #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int BLOCKS = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [WORD_W-1:0]       cpu_wdata,
  output logic [WORD_W-1:0]       cpu_rdata,
  output logic                    cpu_ready,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORDS*WORD_W-1:0] mem_wdata,
  input  logic [WORDS*WORD_W-1:0] mem_rdata,
  input  logic                    mem_ready
);
  localparam int LINE_W = WORDS * WORD_W;
  localparam int OFF_W  = $clog2(LINE_W / 8);
  localparam int IDX_W  = $clog2(BLOCKS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int SEL_W  = $clog2(WORDS);

  logic [IDX_W-1:0]  idx;
  logic              line_valid, line_dirty, fill_en, word_en;
  logic [TAG_W-1:0]  line_tag, fill_tag;
  logic [LINE_W-1:0] line;
  logic [SEL_W-1:0]  word_sel;
  logic [WORD_W-1:0] word_data;

  wbc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst(rst), .idx(idx),
    .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag),
    .fill_en(fill_en), .fill_tag(fill_tag), .mark_dirty(word_en)
  );

  wbc_data_store #(.IDX_W(IDX_W), .WORDS(WORDS), .WORD_W(WORD_W)) data_i (
    .clk(clk), .idx(idx), .line(line),
    .fill_en(fill_en), .fill_line(mem_rdata),
    .word_en(word_en), .word_sel(word_sel), .word_data(word_data)
  );

  wbc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS),
    .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready),
    .idx(idx), .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag),
    .line(line), .fill_en(fill_en), .fill_tag(fill_tag),
    .word_en(word_en), .word_sel(word_sel), .word_data(word_data)
  );
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready
);
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R8
  AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> $past(cpu_req)); // R8
  AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
  AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0)); // R9
  AST_EVICT_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we)); // R5
  AST_FETCH_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ready) |=> (!mem_req ##1 cpu_ready)); // R10
endmodule

bind wbc_top wbc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/wbc_top_tb.sv
module wbc_top_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic         cpu_ready, mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  wbc_top dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic logic [31:0] init_word(input int unsigned wa);
    return (wa * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // backing memory of the bench and architectural view, both word-addressed
  logic [31:0] backing [int unsigned];
  logic [31:0] arch    [int unsigned];

  function automatic logic [31:0] back_word(input int unsigned wa);
    return backing.exists(wa) ? backing[wa] : init_word(wa);
  endfunction
  function automatic logic [31:0] arch_word(input int unsigned wa);
    return arch.exists(wa) ? arch[wa] : init_word(wa);
  endfunction
  function automatic logic [127:0] arch_line(input logic [31:0] base);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = arch_word(int'(base >> 2) + k);
    return l;
  endfunction

  // memory model
  int lat_cnt = 0, lat_lim = 2;
  always @(posedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt >= lat_lim) begin
        lat_cnt = 0;
        lat_lim = 1 + int'($urandom % 4);
        if (mem_we) begin
          for (int k = 0; k < 4; k++) backing[int'(mem_addr >> 2) + k] = mem_wdata[k*32 +: 32];
        end else begin
          for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] <= back_word(int'(mem_addr >> 2) + k);
        end
        mem_ready <= 1'b1;
      end else begin
        lat_cnt++;
      end
    end
  end

  // traffic monitor
  int           op_n = 0;
  logic         op_we   [4];
  logic [31:0]  op_addr [4];
  logic [127:0] op_data [4];
  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (op_n < 4) begin
        op_we[op_n] = mem_we; op_addr[op_n] = mem_addr; op_data[op_n] = mem_wdata;
      end
      op_n++;
    end
  end

  // reference line state
  logic        ref_valid [1024];
  logic        ref_dirty [1024];
  logic [17:0] ref_tag   [1024];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        input string tagname);
    int unsigned ix = addr[13:4];
    logic [17:0] tg = addr[31:14];
    logic [31:0] base = {addr[31:4], 4'b0};
    bit   hit = ref_valid[ix] && ref_tag[ix] == tg;
    bit   evict = !hit && ref_valid[ix] && ref_dirty[ix];
    logic [31:0] vbase = {ref_tag[ix], addr[13:4], 4'b0};
    logic [127:0] vline = arch_line(vbase);
    int   lat = 0;
    op_n = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    do begin
      @(negedge clk); lat++;
    end while (!cpu_ready && lat < 300);
    cpu_req = 1'b0;
    chk(lat < 300, "R8", {tagname, " ready timeout"}, lat, 0);
    if (hit) begin
      chk(op_n == 0, we ? "R4" : "R3", {tagname, " hit mem ops"}, op_n, 0);
      chk(lat == 2, "R8", {tagname, " hit latency"}, lat, 2);
    end else if (evict) begin
      chk(op_n == 2, "R5", {tagname, " evict op count"}, op_n, 2);
      chk(op_we[0] && op_addr[0] == vbase, "R5", {tagname, " evict addr"}, op_addr[0], vbase);
      chk(op_data[0] == vline, "R5", {tagname, " evict data"}, op_data[0], vline);
      chk(!op_we[1] && op_addr[1] == base, "R5", {tagname, " fetch after evict"}, op_addr[1], base);
    end else begin
      chk(op_n == 1 && !op_we[0] && op_addr[0] == base, "R6",
          {tagname, " clean fetch"}, op_addr[0], base);
    end
    ref_valid[ix] = 1'b1; ref_tag[ix] = tg;
    if (!hit) ref_dirty[ix] = 1'b0;
    if (we) begin
      arch[int'(addr >> 2)] = wd;
      ref_dirty[ix] = 1'b1;
    end else begin
      chk(cpu_rdata == arch_word(int'(addr >> 2)), hit ? "R3" : "R7",
          {tagname, " read data"}, cpu_rdata, arch_word(int'(addr >> 2)));
    end
    @(negedge clk);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk); cycles++;
    end
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin
      ref_valid[i] = 1'b0; ref_dirty[i] = 1'b0; ref_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R2", "reset outputs", {cpu_ready, mem_req}, 0);

    // R2 / R6: first access after reset fetches without eviction
    access(1'b0, 32'h0000_0000, 0, "R2 first read");
    // R1: same line, other words and ignored low bits hit
    access(1'b0, 32'h0000_0007, 0, "R1 same line");
    access(1'b0, 32'h0000_000E, 0, "R1 word3");
    // R7: write miss allocates and merges
    access(1'b1, 32'h0000_0024, 32'hCAFE_0001, "R7 write miss");
    access(1'b0, 32'h0000_0024, 0, "R7 readback");
    access(1'b0, 32'h0000_0028, 0, "R7 neighbour word");
    // R4 write hit then R5 eviction on conflicting tag
    access(1'b1, 32'h0000_0020, 32'h1234_5678, "R4 write hit");
    access(1'b0, 32'h0000_4020, 0, "R5 conflict read");
    access(1'b0, 32'h0000_0024, 0, "R5 data survives");
    // top index boundary, R1 tag differs only in top bit
    access(1'b1, 32'hFFFF_FFFC, 32'hDEAD_BEEF, "R1 top index");
    access(1'b0, 32'h7FFF_FFF0, 0, "R1 top bit tag");
    access(1'b0, 32'hFFFF_FFFC, 0, "R10 refetch");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic [9:0]  ix = ($urandom % 5 == 0) ? 10'h3FF : 10'($urandom % 6);
      a = {18'($urandom % 4), ix, 2'($urandom), 2'b00};
      access(1'($urandom % 2), a, $urandom, "R10 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule